// File: doc/BRIEF.md
# Priority Pin Crossbar Decoder

This block decides which on-chip digital signal drives each of 17 general I/O pins. The pins are two 8-pin ports (pins 0 to 15) plus one extra pin (pin 16). A set of enable inputs names the peripheral signals that want a pin. The block hands them pins one after another in a fixed priority order, walking the pins from the lowest index upward. Any pin that is skipped, or held by the UART, is passed over.

For each pin the output is a 5-bit code, and a code of 0 means the pin stays plain GPIO. A second output flags every requested signal that found no pin. The configuration is captured in registers, so the outputs follow a configuration change one clock later. A global enable forces every pin back to GPIO.

Top module: `pinXbar`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, every `pinSel` field is 0 and `sigUnplaced` is all zero.
- R2: When the `xbarEn` value sampled at the last clock edge was 0, every pin code is 0 and `sigUnplaced` is all zero, whatever the other inputs are.
- R3: With the UART enabled, pin 4 carries code 1 (transmit) and pin 5 carries code 2 (receive), even when their skip bits are set. These two pins then leave the pool used for all other signals.
- R4: Signal codes are: 3 SCK, 4 MISO, 5 MOSI, 6 NSS, 7 SDA, 8 SCL, 9 comparator sync, 10 comparator async, 11 clock out, 12/13/14 capture channels 0/1/2, 15 counter clock in, 16 timer 0, 17 timer 1. Requested signals take free pins in ascending code order and ascending pin order. Each code appears on at most one pin. All free pins after the last placed signal stay at code 0.
- R5: A pin i in 0..15 with `skipMask[i]` set never receives codes 3..17. Pin 16 has no skip bit.
- R6: `spiEn` requests SCK, MISO and MOSI. NSS is requested only when `spiFourWire` is also 1. With `spiFourWire` at 0 the NSS pin goes to the next signal in priority.
- R7: SDA and SCL are placed together or not at all. If fewer than two free pins remain for the pair, both are flagged unplaced, and the remaining pins still go to lower-priority signals.
- R8: `sigUnplaced[c-1]` is 1 exactly when signal code c is requested and no pin could be given to it. No pin then carries code c.
- R9: A change of any configuration input shows on the outputs after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xbarEn | input | 1 | Global crossbar enable |
| uartEn | input | 1 | UART transmit/receive pair request |
| spiEn | input | 1 | SPI clock and data lines request |
| spiFourWire | input | 1 | SPI slave-select pin wanted (4-wire mode) |
| smbEn | input | 1 | Two-wire bus pair request |
| cmpSyncEn | input | 1 | Comparator synchronous output request |
| cmpAsyncEn | input | 1 | Comparator asynchronous output request |
| clkOutEn | input | 1 | System clock output request |
| capChEn | input | 3 | Capture/compare channel 0..2 requests |
| cntClkEn | input | 1 | Counter external clock input request |
| tmr0En | input | 1 | Timer 0 input request |
| tmr1En | input | 1 | Timer 1 input request |
| skipMask | input | 16 | Per-pin skip bits for pins 0..15 |
| pinSel | output | 85 | Per-pin code, pin i at bits [5i+4:5i] |
| sigUnplaced | output | 17 | Bit c-1 set: requested code c got no pin |

## Verification
Every combination of the 14 enable inputs is applied with each of four skip masks. The first mask has no skips and isolates priority ordering and the UART hole. The second has scattered skips, which shows whether placement steps over reserved pins. The third leaves only a few low pins plus pin 16, so the pins run out and the pair rule and unplaced flags decide the outcome. The fourth skips all of pins 0..15, so only the UART pins and pin 16 remain. Directed cases fix literal layouts for 3-wire SPI, a split-off bus pair and a held-back update before the clock edge.

// File: rtl/pinXbarPkg.sv
package pinXbarPkg;
  localparam int NUM_PINS = 17;
  localparam int NUM_SIG  = 17;
  localparam int SKIP_W   = 16;
  localparam int SEL_W    = $clog2(NUM_SIG + 1);
  localparam int PIN_IW   = $clog2(NUM_PINS);
  localparam int SIG_IW   = $clog2(NUM_SIG);
  localparam int SKIP_IW  = $clog2(SKIP_W);
  localparam int CAP_CH   = 3;

  localparam int TX_PIN = 4;
  localparam int RX_PIN = 5;

  localparam int CODE_TX     = 1;
  localparam int CODE_RX     = 2;
  localparam int CODE_SCK    = 3;
  localparam int CODE_MISO   = 4;
  localparam int CODE_MOSI   = 5;
  localparam int CODE_NSS    = 6;
  localparam int CODE_SDA    = 7;
  localparam int CODE_SCL    = 8;
  localparam int CODE_CMPS   = 9;
  localparam int CODE_CMPA   = 10;
  localparam int CODE_CLKO   = 11;
  localparam int CODE_CAP0   = 12;
  localparam int CODE_CNTCLK = 15;
  localparam int CODE_TMR0   = 16;
  localparam int CODE_TMR1   = 17;

  typedef struct packed {
    logic                enable;
    logic                uartFixed;
    logic [NUM_SIG-1:0]  sigReq;
    logic [SKIP_W-1:0]   skip;
  } xbarCtrl_t;
endpackage

// File: rtl/pinXbarCtrl.sv
module pinXbarCtrl
  import pinXbarPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              xbarEn,
  input  logic              uartEn,
  input  logic              spiEn,
  input  logic              spiFourWire,
  input  logic              smbEn,
  input  logic              cmpSyncEn,
  input  logic              cmpAsyncEn,
  input  logic              clkOutEn,
  input  logic [CAP_CH-1:0] capChEn,
  input  logic              cntClkEn,
  input  logic              tmr0En,
  input  logic              tmr1En,
  input  logic [SKIP_W-1:0] skipMask,
  output xbarCtrl_t         ctrl
);
  logic              xbarQ, uartQ, spiQ, spi4Q, smbQ, cmpSQ, cmpAQ, clkOQ;
  logic              cntQ, t0Q, t1Q;
  logic [CAP_CH-1:0] capQ;
  logic [SKIP_W-1:0] skipQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xbarQ <= 1'b0; uartQ <= 1'b0; spiQ <= 1'b0; spi4Q <= 1'b0;
      smbQ  <= 1'b0; cmpSQ <= 1'b0; cmpAQ <= 1'b0; clkOQ <= 1'b0;
      cntQ  <= 1'b0; t0Q   <= 1'b0; t1Q   <= 1'b0;
      capQ  <= '0;   skipQ <= '0;
    end else begin
      xbarQ <= xbarEn; uartQ <= uartEn; spiQ <= spiEn; spi4Q <= spiFourWire;
      smbQ  <= smbEn;  cmpSQ <= cmpSyncEn; cmpAQ <= cmpAsyncEn; clkOQ <= clkOutEn;
      cntQ  <= cntClkEn; t0Q <= tmr0En; t1Q <= tmr1En;
      capQ  <= capChEn; skipQ <= skipMask;
    end
  end

  logic [NUM_SIG-1:0] reqRaw;

  always_comb begin
    reqRaw                = '0;
    reqRaw[CODE_TX-1]     = uartQ;
    reqRaw[CODE_RX-1]     = uartQ;
    reqRaw[CODE_SCK-1]    = spiQ;
    reqRaw[CODE_MISO-1]   = spiQ;
    reqRaw[CODE_MOSI-1]   = spiQ;
    reqRaw[CODE_NSS-1]    = spiQ & spi4Q;
    reqRaw[CODE_SDA-1]    = smbQ;
    reqRaw[CODE_SCL-1]    = smbQ;
    reqRaw[CODE_CMPS-1]   = cmpSQ;
    reqRaw[CODE_CMPA-1]   = cmpAQ;
    reqRaw[CODE_CLKO-1]   = clkOQ;
    reqRaw[CODE_CNTCLK-1] = cntQ;
    reqRaw[CODE_TMR0-1]   = t0Q;
    reqRaw[CODE_TMR1-1]   = t1Q;
  end

  // capture channels occupy consecutive codes
  logic [NUM_SIG-1:0] capReq;
  for (genvar c = 0; c < NUM_SIG; c++) begin : g_capReq
    if (c >= CODE_CAP0 - 1 && c < CODE_CAP0 - 1 + CAP_CH) begin : g_on
      assign capReq[c] = capQ[c - (CODE_CAP0 - 1)];
    end else begin : g_off
      assign capReq[c] = 1'b0;
    end
  end

  always_comb begin
    ctrl.enable    = xbarQ;
    ctrl.uartFixed = xbarQ & uartQ;
    ctrl.sigReq    = xbarQ ? (reqRaw | capReq) : '0;
    ctrl.skip      = skipQ;
  end

  AST_NSS_NEEDS_4WIRE: assert property (@(posedge clk) disable iff (!rstN)
    (!spiFourWire) |=> !ctrl.sigReq[CODE_NSS-1]);  // R6

  AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (!xbarEn) |=> (ctrl.sigReq == '0 && !ctrl.uartFixed));  // R2
endmodule

// File: rtl/pinXbarAlloc.sv
module pinXbarAlloc
  import pinXbarPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  xbarCtrl_t                 ctrl,
  output logic [NUM_PINS*SEL_W-1:0] pinSel,
  output logic [NUM_SIG-1:0]        sigUnplaced
);
  logic [NUM_PINS-1:0] freeVec;
  logic [SEL_W-1:0]    rankArr  [NUM_PINS];
  logic [SEL_W-1:0]    slotCode [NUM_PINS];
  logic [SEL_W-1:0]    pinSelArr[NUM_PINS];
  logic [SEL_W-1:0]    freeCnt;

  // pool of pins open to the flowing signals
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      freeVec[PIN_IW'(p)] = ctrl.enable
        && !(ctrl.uartFixed && (p == TX_PIN || p == RX_PIN))
        && !((p < SKIP_W) ? ctrl.skip[SKIP_IW'(p)] : 1'b0);
    end
  end

  // rank of each free pin among all free pins
  always_comb begin
    logic [SEL_W-1:0] cnt;
    cnt = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      rankArr[p] = cnt;
      cnt        = cnt + SEL_W'(freeVec[PIN_IW'(p)]);
    end
    freeCnt = cnt;
  end

  // priority walk: fill slots in rank order
  always_comb begin
    logic [SEL_W-1:0] slot;
    slot        = '0;
    sigUnplaced = '0;
    for (int s = 0; s < NUM_PINS; s++) slotCode[s] = '0;
    for (int k = CODE_SCK; k <= NUM_SIG; k++) begin
      if (k != CODE_SCL && ctrl.sigReq[SIG_IW'(k-1)]) begin
        if (k == CODE_SDA) begin
          if (slot + SEL_W'(1) < freeCnt) begin
            slotCode[slot]             = SEL_W'(CODE_SDA);
            slotCode[slot + SEL_W'(1)] = SEL_W'(CODE_SCL);
            slot                       = slot + SEL_W'(2);
          end else begin
            sigUnplaced[CODE_SDA-1] = 1'b1;
            sigUnplaced[CODE_SCL-1] = 1'b1;
          end
        end else if (slot < freeCnt) begin
          slotCode[slot] = SEL_W'(k);
          slot           = slot + SEL_W'(1);
        end else begin
          sigUnplaced[SIG_IW'(k-1)] = 1'b1;
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p == TX_PIN || p == RX_PIN) begin : g_fixed
      assign pinSelArr[p] = ctrl.uartFixed
        ? SEL_W'((p == TX_PIN) ? CODE_TX : CODE_RX)
        : (freeVec[p] ? slotCode[rankArr[p]] : '0);
    end else begin : g_flow
      assign pinSelArr[p] = freeVec[p] ? slotCode[rankArr[p]] : '0;
    end
    assign pinSel[p*SEL_W +: SEL_W] = pinSelArr[p];

    if (p < SKIP_W) begin : g_skipChk
      if (p != TX_PIN && p != RX_PIN) begin : g_plain
        AST_SKIP_GPIO: assert property (@(posedge clk) disable iff (!rstN)
          ctrl.skip[p] |-> (pinSelArr[p] == '0));  // R5
      end
    end
  end

  // one-hot usage of every signal code across pins
  logic [NUM_PINS-1:0] codeHit [NUM_SIG];
  for (genvar c = 0; c < NUM_SIG; c++) begin : g_code
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_hit
      assign codeHit[c][p] = (pinSelArr[p] == SEL_W'(c + 1));
    end
    AST_CODE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(codeHit[c]));  // R4
    AST_UNPLACED_ABSENT: assert property (@(posedge clk) disable iff (!rstN)
      sigUnplaced[c] |-> (codeHit[c] == '0));  // R8
  end

  AST_UART_PINS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.uartFixed |-> (pinSelArr[TX_PIN] == SEL_W'(CODE_TX)
                        && pinSelArr[RX_PIN] == SEL_W'(CODE_RX)));  // R3

  AST_PAIR_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    (|codeHit[CODE_SDA-1]) == (|codeHit[CODE_SCL-1]));  // R7

  AST_DISABLED_GPIO: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.enable |-> (pinSel == '0 && sigUnplaced == '0));  // R2
endmodule

// File: rtl/pinXbar.sv
module pinXbar
  import pinXbarPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      xbarEn,
  input  logic                      uartEn,
  input  logic                      spiEn,
  input  logic                      spiFourWire,
  input  logic                      smbEn,
  input  logic                      cmpSyncEn,
  input  logic                      cmpAsyncEn,
  input  logic                      clkOutEn,
  input  logic [CAP_CH-1:0]         capChEn,
  input  logic                      cntClkEn,
  input  logic                      tmr0En,
  input  logic                      tmr1En,
  input  logic [SKIP_W-1:0]         skipMask,
  output logic [NUM_PINS*SEL_W-1:0] pinSel,
  output logic [NUM_SIG-1:0]        sigUnplaced
);
  xbarCtrl_t ctrl;

  pinXbarCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .xbarEn     (xbarEn),
    .uartEn     (uartEn),
    .spiEn      (spiEn),
    .spiFourWire(spiFourWire),
    .smbEn      (smbEn),
    .cmpSyncEn  (cmpSyncEn),
    .cmpAsyncEn (cmpAsyncEn),
    .clkOutEn   (clkOutEn),
    .capChEn    (capChEn),
    .cntClkEn   (cntClkEn),
    .tmr0En     (tmr0En),
    .tmr1En     (tmr1En),
    .skipMask   (skipMask),
    .ctrl       (ctrl)
  );

  pinXbarAlloc alloc_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .pinSel     (pinSel),
    .sigUnplaced(sigUnplaced)
  );
endmodule

// File: tb/pinXbar_tb.sv
`timescale 1ns/1ps
module pinXbar_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] cfg = '0;
  logic [15:0] skipMask = '0;
  logic [84:0] pinSel;
  logic [16:0] sigUnplaced;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  always #2.5 clk = ~clk;

  // cfg bits: 0 xbar,1 uart,2 spi,3 spi4,4 smb,5 cmpS,6 cmpA,7 clkOut,8..10 cap,11 cnt,12 t0,13 t1
  pinXbar dut_i (
    .clk(clk), .rstN(rstN),
    .xbarEn(cfg[0]), .uartEn(cfg[1]), .spiEn(cfg[2]), .spiFourWire(cfg[3]),
    .smbEn(cfg[4]), .cmpSyncEn(cfg[5]), .cmpAsyncEn(cfg[6]), .clkOutEn(cfg[7]),
    .capChEn(cfg[10:8]), .cntClkEn(cfg[11]), .tmr0En(cfg[12]), .tmr1En(cfg[13]),
    .skipMask(skipMask), .pinSel(pinSel), .sigUnplaced(sigUnplaced)
  );

  function automatic bit isBlocked(input int p, input bit uart, input logic [15:0] sk);
    if (uart && (p == 4 || p == 5)) return 1'b1;
    if (p < 16 && sk[p]) return 1'b1;
    return 1'b0;
  endfunction

  // model: cursor walk over pins, signals in priority order
  function automatic void refModel(input logic [13:0] c, input logic [15:0] sk,
                                   output logic [84:0] eSel, output logic [16:0] eUnp);
    bit req [1:17];
    int cur, a, b;
    eSel = '0; eUnp = '0;
    if (!c[0]) return;
    for (int i = 1; i <= 17; i++) req[i] = 1'b0;
    req[3] = c[2]; req[4] = c[2]; req[5] = c[2]; req[6] = c[2] & c[3];
    req[7] = c[4]; req[9] = c[5]; req[10] = c[6]; req[11] = c[7];
    req[12] = c[8]; req[13] = c[9]; req[14] = c[10]; req[15] = c[11];
    req[16] = c[12]; req[17] = c[13];
    if (c[1]) begin eSel[20 +: 5] = 5'd1; eSel[25 +: 5] = 5'd2; end
    cur = 0;
    for (int code = 3; code <= 17; code++) begin
      if (code == 8 || !req[code]) continue;
      a = cur;
      while (a < 17 && isBlocked(a, c[1], sk)) a++;
      if (code == 7) begin
        b = a + 1;
        while (b < 17 && isBlocked(b, c[1], sk)) b++;
        if (b < 17) begin
          eSel[a*5 +: 5] = 5'd7; eSel[b*5 +: 5] = 5'd8; cur = b + 1;
        end else begin
          eUnp[6] = 1'b1; eUnp[7] = 1'b1;
        end
      end else if (a < 17) begin
        eSel[a*5 +: 5] = 5'(code); cur = a + 1;
      end else begin
        eUnp[code-1] = 1'b1;
      end
    end
  endfunction

  task automatic check(input bit ok, input string req, input logic [101:0] act,
                       input logic [101:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic applyAndCheck(input logic [13:0] c, input logic [15:0] sk, input string req);
    logic [84:0] eSel; logic [16:0] eUnp;
    cfg = c; skipMask = sk;
    @(posedge clk); #1;
    refModel(c, sk, eSel, eUnp);
    check(pinSel == eSel && sigUnplaced == eUnp, req, {sigUnplaced, pinSel}, {eUnp, eSel});
  endtask

  function automatic logic [4:0] pinCode(input int p);
    return pinSel[p*5 +: 5];
  endfunction

  initial begin
    logic [15:0] masks [4];
    masks[0] = 16'h0000; masks[1] = 16'h9249; masks[2] = 16'hFFF0; masks[3] = 16'hFFFF;

    // R1: reset holds every output at zero
    cfg = 14'h3FFF; skipMask = '0;
    repeat (3) @(posedge clk);
    #1;
    check(pinSel == '0 && sigUnplaced == '0, "R1 reset", {sigUnplaced, pinSel}, '0);
    rstN = 1'b1;
    #1;
    check(pinSel == '0 && sigUnplaced == '0, "R1 after release", {sigUnplaced, pinSel}, '0);

    // R2: disabled crossbar with everything requested
    applyAndCheck(14'h3FFE, 16'h0000, "R2 disabled");
    check(pinSel == '0, "R2 all gpio", {17'd0, pinSel}, '0);

    // R3/R4: uart plus everything, no skips
    applyAndCheck(14'h3FFF, 16'h0000, "R3 R4 full");
    check(pinCode(4) == 5'd1 && pinCode(5) == 5'd2, "R3 uart pins",
          {92'd0, pinCode(5), pinCode(4)}, {92'd0, 5'd2, 5'd1});
    check(pinCode(6) == 5'd7 && pinCode(16) == 5'd17, "R4 order around uart",
          {92'd0, pinCode(16), pinCode(6)}, {92'd0, 5'd17, 5'd7});

    // R3: uart pins stay fixed even when skipped
    applyAndCheck(14'h0003, 16'h0030, "R3 skipped uart pins");
    check(pinCode(4) == 5'd1 && pinCode(5) == 5'd2, "R3 uart over skip",
          {92'd0, pinCode(5), pinCode(4)}, {92'd0, 5'd2, 5'd1});

    // R6: 3-wire SPI, comparator follows MOSI directly
    applyAndCheck(14'h0025, 16'h0000, "R6 three wire");
    check(pinCode(3) == 5'd9, "R6 nss absent", {97'd0, pinCode(3)}, {97'd0, 5'd9});

    // R7/R8: only pin 16 free, bus pair cannot fit, comparator takes it
    applyAndCheck(14'h0031, 16'hFFFF, "R7 R8 pair split");
    check(pinCode(16) == 5'd9 && sigUnplaced == 17'h000C0, "R7 pair dropped",
          {sigUnplaced, 80'd0, pinCode(16)}, {17'h000C0, 80'd0, 5'd9});

    // R5: skipped pin is passed over
    applyAndCheck(14'h0021, 16'h0001, "R5 skip pin0");
    check(pinCode(0) == 5'd0 && pinCode(1) == 5'd9, "R5 next free",
          {92'd0, pinCode(1), pinCode(0)}, {92'd0, 5'd9, 5'd0});

    // R9: change held until the clock edge
    cfg = 14'h1001; skipMask = '0;
    @(posedge clk); #1;
    cfg = 14'h2001;
    #1;
    check(pinCode(0) == 5'd16, "R9 before edge", {97'd0, pinCode(0)}, {97'd0, 5'd16});
    @(posedge clk); #1;
    check(pinCode(0) == 5'd17, "R9 after edge", {97'd0, pinCode(0)}, {97'd0, 5'd17});

    // sweep: R2 R3 R4 R5 R6 R7 R8 over all enables and four masks
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 16384; v++) begin
        applyAndCheck(14'(v), masks[m], "R2-sweep R4 R5 R7 R8");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule